// File: doc/BRIEF.md
# Comparator Output Conditioning and Gated Counter

This block takes the raw result bits of two comparators and prepares them for use elsewhere in the chip. Each result can have its polarity flipped by its own invert bit. The conditioned value is what downstream logic sees. It can also be steered onto a pin in place of the ordinary port data. The pin's direction bit keeps control of the output enable in either mode.

The second comparator can also gate a 16-bit event counter. A select bit chooses the counter's gate: either an external gate pin or the conditioned result of comparator 2. The counter clock arrives as a pair of one-cycle pulses, one for its rising phase and one for its falling phase. It first passes through a prescaler that divides by 1, 2, 4 or 8. When the sync bit is set, the comparator 2 gate value is captured on the falling phase of the prescaled clock. The counter advances only on the rising phase, so a gate change can never land on an increment. When the sync bit is clear, the conditioned value is used directly. Everything runs in one system clock domain, and all control bits arrive as plain register inputs.

Top module: `cmp_gate_timer`

## Requirements
- R1: `cmpOut[i]` equals `cmpRaw[i]` XOR `invEn[i]` in the same cycle, for each channel i (channel 1 is comparator 2).
- R2: `pinDrive[i]` carries `cmpOut[i]` when `pinOutEn[i]` is 1 and `gpioOut[i]` when it is 0, combinationally.
- R3: `pinOe[i]` is the inverse of `pinTris[i]` (tris 1 = high impedance) in both the comparator-output mode and the port-data mode.
- R4: The prescale ratio is 2 to the power of `preSel` (0→1, 1→2, 2→4, 3→8). A prescaled rise occurs on the first source rise after reset and on every ratio-th source rise after that. A prescaled fall occurs on a source fall that comes after a prescaled rise and before the next source rise.
- R5: On a system clock edge with a prescaled rise, `count` goes up by one, visible in the next cycle, if and only if `cntEn` is 1 and the selected gate is 1. Otherwise `count` holds.
- R6: `gateSel` = 0 selects `extGate` as the gate. `gateSel` = 1 selects the comparator 2 gate path.
- R7: With `syncEn` = 1, the comparator 2 gate is the value of `cmpOut[1]` captured at the most recent prescaled fall. Changes of `cmpOut[1]` between prescaled falls have no effect on counting.
- R8: With `syncEn` = 0, the comparator 2 gate is the present `cmpOut[1]`, with no capture.
- R9: An increment from the all-ones value wraps `count` to zero. `ovf` is 1 for exactly the one cycle that follows that edge.
- R10: Reset clears `count`, `ovf`, the prescaler phase and the captured comparator 2 value (captured value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpRaw | input | NCH | Raw comparator result bits |
| invEn | input | NCH | Per-channel polarity invert |
| pinOutEn | input | NCH | Route conditioned result to pin instead of port data |
| pinTris | input | NCH | Pin direction, 1 = high impedance |
| gpioOut | input | NCH | Ordinary port data for each pin |
| extGate | input | 1 | External counter gate pin, active high |
| gateSel | input | 1 | Gate source: 0 external pin, 1 comparator 2 |
| syncEn | input | 1 | Capture comparator 2 on prescaled falling phase |
| cntEn | input | 1 | Counter enable |
| preSel | input | PRE_SEL_W | Prescale exponent |
| srcRise | input | 1 | One-cycle pulse: counter clock source rising phase |
| srcFall | input | 1 | One-cycle pulse: counter clock source falling phase |
| cmpOut | output | NCH | Conditioned comparator results |
| pinDrive | output | NCH | Pin output value |
| pinOe | output | NCH | Pin output enable |
| count | output | CNT_W | Counter value |
| ovf | output | 1 | One-cycle wrap pulse |

## Verification
The bench builds the block with CNT_W = 8. At that width the wrap from all ones to zero, and the overflow pulse, take only a few hundred increments. PRE_SEL_W stays at 2, so all four divide ratios are used, including changes of ratio in the middle of a prescaler cycle. At ratio 2 only every other source fall is a prescaled fall, so the sync capture can be seen ignoring the off-phase falls.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  // Strobes from the prescaler control to the datapath
  typedef struct packed {
    logic preRise;  // prescaled clock rising phase
    logic preFall;  // prescaled clock falling phase
  } tmrStrobe_t;
endpackage

// File: rtl/cgt_ctrl.sv
module cgt_ctrl
  import cgt_pkg::*;
#(
  parameter int PRE_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srcRise,
  input  logic                 srcFall,
  input  logic [PRE_SEL_W-1:0] preSel,
  output tmrStrobe_t           strb
);
  localparam int MAX_RATIO = 1 << ((1 << PRE_SEL_W) - 1);
  localparam int PHASE_W   = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;
  localparam logic [PHASE_W:0] ONE = 1;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W:0]   ratio;
  logic [PHASE_W:0]   lastPhase;
  logic [PHASE_W:0]   fallPhase;
  logic [PHASE_W:0]   phaseExt;

  always_comb begin
    ratio     = ONE << preSel;
    lastPhase = ratio - ONE;
    fallPhase = (ratio == ONE) ? '0 : ONE;
    phaseExt  = {1'b0, phase};
    strb.preRise = srcRise && (phase == '0);
    strb.preFall = srcFall && (phaseExt == fallPhase);
  end

  // Phase counts source rises modulo the ratio
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (srcRise) begin
      if (phaseExt >= lastPhase) phase <= '0;
      else                       phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/cgt_dp.sv
module cgt_dp
  import cgt_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   cmpRaw,
  input  logic [NCH-1:0]   invEn,
  input  logic [NCH-1:0]   pinOutEn,
  input  logic [NCH-1:0]   pinTris,
  input  logic [NCH-1:0]   gpioOut,
  input  logic             extGate,
  input  logic             gateSel,
  input  logic             syncEn,
  input  logic             cntEn,
  input  tmrStrobe_t       strb,
  output logic [NCH-1:0]   cmpOut,
  output logic [NCH-1:0]   pinDrive,
  output logic [NCH-1:0]   pinOe,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int GATE_CH = 1;  // comparator 2

  // Per-channel polarity and pin path
  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    assign cmpOut[ch]   = cmpRaw[ch] ^ invEn[ch];
    assign pinDrive[ch] = pinOutEn[ch] ? cmpOut[ch] : gpioOut[ch];
    assign pinOe[ch]    = ~pinTris[ch];
  end

  // Comparator 2 capture on the prescaled falling phase
  logic c2Latch;
  always_ff @(posedge clk) begin
    if (!rstN)             c2Latch <= 1'b0;
    else if (strb.preFall) c2Latch <= cmpOut[GATE_CH];
  end

  logic c2Gate, gateVal, incr;
  always_comb begin
    c2Gate  = syncEn ? c2Latch : cmpOut[GATE_CH];
    gateVal = gateSel ? c2Gate : extGate;
    incr    = strb.preRise && cntEn && gateVal;
  end

  // Counter on the prescaled rising phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= incr && (&count);
      if (incr) count <= count + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.preRise |=> $stable(count)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.preRise && cntEn && gateVal) |=> (count == CNT_W'($past(count) + 1'b1))); // R5
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.preFall |=> $stable(c2Latch)); // R7
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (count == '0)); // R9
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !ovf); // R9
endmodule

// File: rtl/cmp_gate_timer.sv
module cmp_gate_timer
  import cgt_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int CNT_W     = 16,
  parameter int PRE_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       cmpRaw,
  input  logic [NCH-1:0]       invEn,
  input  logic [NCH-1:0]       pinOutEn,
  input  logic [NCH-1:0]       pinTris,
  input  logic [NCH-1:0]       gpioOut,
  input  logic                 extGate,
  input  logic                 gateSel,
  input  logic                 syncEn,
  input  logic                 cntEn,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 srcRise,
  input  logic                 srcFall,
  output logic [NCH-1:0]       cmpOut,
  output logic [NCH-1:0]       pinDrive,
  output logic [NCH-1:0]       pinOe,
  output logic [CNT_W-1:0]     count,
  output logic                 ovf
);
  tmrStrobe_t strb;

  cgt_ctrl #(.PRE_SEL_W(PRE_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcRise(srcRise), .srcFall(srcFall),
    .preSel(preSel), .strb(strb)
  );

  cgt_dp #(.NCH(NCH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .invEn(invEn),
    .pinOutEn(pinOutEn), .pinTris(pinTris), .gpioOut(gpioOut),
    .extGate(extGate), .gateSel(gateSel), .syncEn(syncEn), .cntEn(cntEn),
    .strb(strb), .cmpOut(cmpOut), .pinDrive(pinDrive), .pinOe(pinOe),
    .count(count), .ovf(ovf)
  );
endmodule

// File: tb/cmp_gate_timer_bench.sv
module cmp_gate_timer_bench;
  localparam int CW = 8;

  // 100 MHz clock: period of 10 time units (ns)
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic [1:0]    cmpRaw = '0, invEn = '0, pinOutEn = '0, pinTris = '0, gpioOut = '0;
  logic          extGate = 1'b0, gateSel = 1'b0, syncEn = 1'b0, cntEn = 1'b0;
  logic [1:0]    preSel = '0;
  logic          srcRise = 1'b0, srcFall = 1'b0;
  logic [1:0]    cmpOut, pinDrive, pinOe;
  logic [CW-1:0] count;
  logic          ovf;

  cmp_gate_timer #(.CNT_W(CW)) u_cmp_gate_timer (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .invEn(invEn), .pinOutEn(pinOutEn),
    .pinTris(pinTris), .gpioOut(gpioOut), .extGate(extGate), .gateSel(gateSel),
    .syncEn(syncEn), .cntEn(cntEn), .preSel(preSel), .srcRise(srcRise),
    .srcFall(srcFall), .cmpOut(cmpOut), .pinDrive(pinDrive), .pinOe(pinOe),
    .count(count), .ovf(ovf)
  );

  typedef struct {
    string         tag;
    logic [CW-1:0] cnt;
    logic          ov;
    logic [1:0]    cOut;
    logic [1:0]    pDrv;
    logic [1:0]    pOe;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails  = 0;
  int wraps  = 0;

  // Reference state, built from the requirements
  int            mPre   = 0;
  logic          mLatch = 1'b0;
  logic [CW-1:0] mCnt   = '0;
  logic          mOvf   = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of pulses and queues the expected outcome
  task automatic step(bit rise, bit fall, string tag);
    exp_t e;
    logic [1:0] co;
    int ratio;
    bit pr, pf, g2, g, inc;
    @(negedge clk);
    srcRise = rise;
    srcFall = fall;
    co    = cmpRaw ^ invEn;
    ratio = 1 << preSel;
    pr    = rise && (mPre == 0);
    pf    = fall && (mPre == (1 % ratio));
    g2    = syncEn ? mLatch : co[1];
    g     = gateSel ? g2 : extGate;
    inc   = pr && cntEn && g;
    mOvf  = inc && (mCnt == '1);
    if (mOvf) wraps++;
    if (inc) mCnt = mCnt + 1'b1;
    if (pf) mLatch = co[1];
    if (rise) mPre = (mPre >= ratio - 1) ? 0 : mPre + 1;
    e.tag  = tag;
    e.cnt  = mCnt;
    e.ov   = mOvf;
    e.cOut = co;
    e.pDrv = (pinOutEn & co) | (~pinOutEn & gpioOut);
    e.pOe  = ~pinTris;
    sbq.push_back(e);
    @(posedge clk);
    #3;
  endtask

  // Monitor: compares each queued item just after the edge it belongs to
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk("R1", "cmpOut", 32'(cmpOut), 32'(e.cOut));
      chk("R2", "pinDrive", 32'(pinDrive), 32'(e.pDrv));
      chk("R3", "pinOe", 32'(pinOe), 32'(e.pOe));
      chk(e.tag, "count", 32'(count), 32'(e.cnt));
      chk("R9", "ovf", 32'(ovf), 32'(e.ov));
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R10", "count after reset", 32'(count), 0);
    chk("R10", "ovf after reset", 32'(ovf), 0);

    // R10: captured value starts at 0, so the comparator 2 gate is closed
    #1;
    syncEn = 1'b1; gateSel = 1'b1; cntEn = 1'b1; cmpRaw = 2'b10;
    step(1, 0, "R10");
    step(0, 0, "R10");

    // R1 R2 R3: polarity and pin path over all raw/invert combinations
    cntEn = 1'b0;
    for (int k = 0; k < 16; k++) begin
      cmpRaw   = k[1:0];
      invEn    = k[3:2];
      pinOutEn = k[1:0] ^ k[3:2] ^ {k[0], k[3]};
      pinTris  = k[2:1];
      gpioOut  = ~k[1:0];
      step(0, 0, "R1");
    end

    // R4 R5: each prescale ratio with an open external gate
    invEn = '0; cmpRaw = '0; cntEn = 1'b1; gateSel = 1'b0; syncEn = 1'b0; extGate = 1'b1;
    for (int ps = 0; ps < 4; ps++) begin
      preSel = ps[1:0];
      for (int n = 0; n < 10; n++) begin
        step(1, 0, "R4");
        step(0, 1, "R4");
        step(0, 0, "R4");
      end
    end

    // R5: closed gate, then disabled counter
    preSel = 2'd0;
    extGate = 1'b0;
    for (int n = 0; n < 4; n++) step(1, 0, "R5");
    extGate = 1'b1; cntEn = 1'b0;
    for (int n = 0; n < 4; n++) step(1, 0, "R5");

    // R8 R6: unsynchronized comparator 2 gate versus external gate
    cntEn = 1'b1; gateSel = 1'b1; syncEn = 1'b0;
    for (int k = 0; k < 8; k++) begin
      cmpRaw  = {k[0], 1'b0};
      invEn   = {k[2], 1'b0};
      extGate = ~k[0];
      step(1, 0, "R8");
      step(0, 1, "R8");
    end
    gateSel = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cmpRaw  = {1'b1, 1'b0};
      invEn   = '0;
      extGate = k[0];
      step(1, 0, "R6");
    end

    // R7: captured gate at ratio 2, comparator changes between falls
    gateSel = 1'b1; syncEn = 1'b1; preSel = 2'd1; invEn = '0;
    for (int k = 0; k < 12; k++) begin
      cmpRaw[1] = k[1] ^ k[0];
      step(1, 0, "R7");
      cmpRaw[1] = k[2];
      step(0, 1, "R7");
      cmpRaw[1] = ~k[2];
      step(0, 0, "R7");
    end

    // R9: run past the all-ones value
    gateSel = 1'b0; syncEn = 1'b0; preSel = 2'd0; extGate = 1'b1; cntEn = 1'b1;
    for (int n = 0; n < 300; n++) step(1, 0, "R9");
    step(0, 0, "R9");
    chk("R9", "wrap reached", 32'(wraps > 0), 1);

    repeat (3) @(posedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule